// File: doc/BRIEF.md
# Serial Register-Access Slave Port

This block lets an external host reach a bank of internal registers over a four-wire synchronous serial link: serial clock, active-low select, data in, and a data out that can be released to high impedance. The serial clock and select are plain inputs. The block samples them in its own system clock and finds their edges there. The system clock must run at least four times faster than the serial clock.

Each transaction opens with a command byte. That byte carries a direction flag and a register address. A data phase follows, and its length in whole bytes comes from a per-address width table. Register values travel right-justified and most significant bit first. A write is handed to the register bank as a one-cycle strobe, and only once the last data bit has arrived. A read copies the whole register into an output shifter in one step, so changes made inside the chip during the transfer cannot tear the value. When a data phase ends, the port is ready for another command without a new select cycle. If select rises early, the transaction is abandoned.

The serial lines carry no handshake, so the stream-style valid/ready convention does not apply at this edge. The register bank port is a plain address/strobe/data interface with a combinational read path and no back-pressure.

Top module: `serreg_port`

## Requirements
- R1: The first 8 bits sampled after `cs_n` falls form a command byte, received MSB first. Bit 7 = 1 means write and 0 means read. Bits 4:0 are the register address. Bits 6:5 are ignored.
- R2: Default width table: addresses 0 to 23 are mapped, and 24 to 31 are unmapped. For a mapped address, addr[1:0] selects the width: 0 gives 8 bits, 1 gives 12, 2 gives 16, 3 gives 24. The data phase is 1, 2, 2 or 3 bytes respectively.
- R3: Write data is sampled on falling `sclk` edges, MSB first, right-justified in the byte frame. Frame bits above the register width are dropped. For example, a 12-bit register discards the upper 4 bits of its first byte.
- R4: A completed write to a mapped address produces exactly one single-cycle `wr_en` pulse, carrying `wr_addr` and `wr_data`. The pulse comes after the last data bit is sampled.
- R5: A read command to a mapped address pulses `rd_en` for one cycle when the command byte completes. The `rd_data` value present in that cycle is the value returned. Later changes to `rd_data` have no effect on the transfer.
- R6: Read data is shifted out on `sdo`, changing on rising `sclk` edges, MSB first. It fills the whole byte frame, and frame bits above the register width read as 0.
- R7: `sdo_oe` is low before the first rising edge that follows a read command. It stays high for every data bit. It drops after the falling edge of the last data pulse.
- R8: After a data phase completes, the next 8 bits under the same select form a new command byte.
- R9: Raising `cs_n` forces `sdo_oe` low at once and discards a partial write, so no `wr_en` is produced. The next select starts with a command byte.
- R10: An unmapped address uses a 1-byte data phase. A read of it returns 8 zero bits. A write to it produces no `wr_en`.
- R11: After reset, `sdo_oe`, `sdo`, `wr_en` and `rd_en` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sclk | input | 1 | Serial clock, idles low |
| cs_n | input | 1 | Active-low select |
| sdi | input | 1 | Serial data in |
| sdo | output | 1 | Serial data out, 0 when not enabled |
| sdo_oe | output | 1 | Output enable for the external tri-state driver |
| rd_addr | output | 5 | Register bank read address |
| rd_en | output | 1 | One-cycle strobe marking the snapshot cycle |
| rd_data | input | 24 | Register bank read data, combinational from rd_addr |
| wr_en | output | 1 | One-cycle write strobe |
| wr_addr | output | 5 | Write address |
| wr_data | output | 24 | Write data, masked to the register width |

## Verification
Several properties are checked on every cycle:
- `sdo_oe` is only ever high in the read data phase.
- The enable only rises through a data shift.
- Select going high clears the output shifter.
- Write strobes are single-cycle, hit only mapped addresses, and carry no bits above the register width.

Bit order and the byte framing of each width can only be shown by the bench's transactions. The same holds for the snapshot surviving a mid-transfer change, back-to-back commands under one select, and the release point of the output.

// File: rtl/srp_pkg.sv
package srp_pkg;
  typedef enum logic [1:0] {PH_CMD, PH_WR, PH_RD} phase_e;

  localparam int unsigned CMD_BITS  = 8;
  localparam int unsigned FRAME_MAX = 24;
  localparam int unsigned CNT_W     = 5;

  // width code: 0 = 8 bits, 1 = 12 bits, 2 = 16 bits, 3 = 24 bits
  function automatic logic [CNT_W-1:0] code_data_bits(input logic [1:0] code);
    case (code)
      2'd0:    return CNT_W'(8);
      2'd1:    return CNT_W'(12);
      2'd2:    return CNT_W'(16);
      default: return CNT_W'(24);
    endcase
  endfunction

  function automatic logic [CNT_W-1:0] code_frame_bits(input logic [1:0] code);
    case (code)
      2'd0:    return CNT_W'(8);
      2'd1:    return CNT_W'(16);
      2'd2:    return CNT_W'(16);
      default: return CNT_W'(24);
    endcase
  endfunction
endpackage

// File: rtl/srp_edge_sync.sv
module srp_edge_sync (
  input  logic clk,
  input  logic rst_n,
  input  logic sclk,
  input  logic cs_n,
  input  logic sdi,
  output logic sclk_rise,
  output logic sclk_fall,
  output logic selected,
  output logic bit_in
);
  logic sclk_d, sclk_p, cs_d, sdi_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sclk_d <= 1'b0;
      sclk_p <= 1'b0;
      cs_d   <= 1'b1;
      sdi_d  <= 1'b0;
    end else begin
      sclk_d <= sclk;
      sclk_p <= sclk_d;
      cs_d   <= cs_n;
      sdi_d  <= sdi;
    end
  end

  assign selected  = ~cs_d;
  assign sclk_rise = selected &  sclk_d & ~sclk_p;
  assign sclk_fall = selected & ~sclk_d &  sclk_p;
  assign bit_in    = sdi_d;
endmodule

// File: rtl/srp_width_lut.sv
module srp_width_lut
  import srp_pkg::*;
#(
  parameter int unsigned ADDR_W = 5,
  parameter logic [(1<<ADDR_W)-1:0]   MAP_MASK = '1,
  parameter logic [2*(1<<ADDR_W)-1:0] WCODE    = '0
) (
  input  logic [ADDR_W-1:0]    addr,
  output logic                 mapped,
  output logic [CNT_W-1:0]     frame_bits,
  output logic [FRAME_MAX-1:0] data_mask
);
  localparam int unsigned NREG = 1 << ADDR_W;

  logic [1:0] code_tab [NREG];

  for (genvar a = 0; a < NREG; a++) begin : g_tab
    assign code_tab[a] = WCODE[2*a +: 2];
  end

  logic [1:0]       code;
  logic [CNT_W-1:0] dbits;

  assign code   = code_tab[addr];
  assign mapped = MAP_MASK[addr];
  assign dbits  = code_data_bits(code);

  always_comb begin
    if (mapped) begin
      frame_bits = code_frame_bits(code);
      data_mask  = (FRAME_MAX'(1) << dbits) - FRAME_MAX'(1);
    end else begin
      frame_bits = CNT_W'(8);
      data_mask  = '0;
    end
  end
endmodule

// File: rtl/srp_tx_shifter.sv
module srp_tx_shifter #(
  parameter int unsigned FRAME_W = 24,
  parameter int unsigned CW      = 5
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               load,
  input  logic [FRAME_W-1:0] load_frame,
  input  logic [CW-1:0]      load_bits,
  input  logic               shift,
  input  logic               release_i,
  input  logic               abort,
  output logic               sdo_q,
  output logic               oe_q,
  output logic               empty
);
  logic [FRAME_W-1:0] sr;
  logic [CW-1:0]      left;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sr    <= '0;
      left  <= '0;
      sdo_q <= 1'b0;
      oe_q  <= 1'b0;
    end else if (abort) begin
      left  <= '0;
      sdo_q <= 1'b0;
      oe_q  <= 1'b0;
    end else if (load) begin
      sr   <= load_frame;
      left <= load_bits;
    end else if (shift && left != '0) begin
      sdo_q <= sr[FRAME_W-1];
      sr    <= {sr[FRAME_W-2:0], 1'b0};
      left  <= left - CW'(1);
      oe_q  <= 1'b1;
    end else if (release_i) begin
      sdo_q <= 1'b0;
      oe_q  <= 1'b0;
    end
  end

  assign empty = (left == '0);

  // R9: select high clears the shifter and the enable
  p_abort_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
    abort |=> (!oe_q && empty));

  // R7: the enable only turns on through a data shift
  p_oe_by_shift_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(oe_q) |-> $past(shift));
endmodule

// File: rtl/serreg_port.sv
module serreg_port
  import srp_pkg::*;
#(
  parameter int unsigned ADDR_W = 5,
  parameter logic [(1<<ADDR_W)-1:0]   MAP_MASK = 32'h00FF_FFFF,
  parameter logic [2*(1<<ADDR_W)-1:0] WCODE    = 64'hE4E4_E4E4_E4E4_E4E4
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 sclk,
  input  logic                 cs_n,
  input  logic                 sdi,
  output logic                 sdo,
  output logic                 sdo_oe,
  output logic [ADDR_W-1:0]    rd_addr,
  output logic                 rd_en,
  input  logic [FRAME_MAX-1:0] rd_data,
  output logic                 wr_en,
  output logic [ADDR_W-1:0]    wr_addr,
  output logic [FRAME_MAX-1:0] wr_data
);
  localparam int unsigned DW = FRAME_MAX;

  logic sclk_rise, sclk_fall, selected, bit_in;

  srp_edge_sync u_sync (
    .clk      (clk),
    .rst_n    (rst_n),
    .sclk     (sclk),
    .cs_n     (cs_n),
    .sdi      (sdi),
    .sclk_rise(sclk_rise),
    .sclk_fall(sclk_fall),
    .selected (selected),
    .bit_in   (bit_in)
  );

  phase_e                phase_q;
  logic [CMD_BITS-2:0]   cmd_sr;
  logic [CMD_BITS-1:0]   cmd_full;
  logic [CNT_W-1:0]      cnt_q;
  logic                  cmd_last, cmd_is_wr;

  assign cmd_full  = {cmd_sr, bit_in};
  assign cmd_is_wr = cmd_full[CMD_BITS-1];
  assign cmd_last  = (phase_q == PH_CMD) && sclk_fall && (cnt_q == CNT_W'(CMD_BITS-1));
  assign rd_addr   = cmd_full[ADDR_W-1:0];

  logic             lut_mapped;
  logic [CNT_W-1:0] lut_frame;
  logic [DW-1:0]    lut_mask;

  srp_width_lut #(
    .ADDR_W  (ADDR_W),
    .MAP_MASK(MAP_MASK),
    .WCODE   (WCODE)
  ) u_lut (
    .addr      (rd_addr),
    .mapped    (lut_mapped),
    .frame_bits(lut_frame),
    .data_mask (lut_mask)
  );

  // read snapshot, left-aligned inside the shifter
  logic [DW-1:0] snap, load_frame;
  logic          tx_load, tx_shift, tx_release, tx_sdo, tx_oe, tx_empty;

  assign snap       = rd_data & lut_mask;
  assign load_frame = snap << (CNT_W'(DW) - lut_frame);
  assign tx_load    = cmd_last && !cmd_is_wr;
  assign tx_shift   = sclk_rise && (phase_q == PH_RD);
  assign tx_release = sclk_fall && (phase_q == PH_RD) && tx_empty && tx_oe;
  assign rd_en      = tx_load && lut_mapped;

  srp_tx_shifter #(
    .FRAME_W(DW),
    .CW     (CNT_W)
  ) u_tx (
    .clk       (clk),
    .rst_n     (rst_n),
    .load      (tx_load),
    .load_frame(load_frame),
    .load_bits (lut_frame),
    .shift     (tx_shift),
    .release_i (tx_release),
    .abort     (!selected),
    .sdo_q     (tx_sdo),
    .oe_q      (tx_oe),
    .empty     (tx_empty)
  );

  assign sdo_oe = tx_oe & ~cs_n;
  assign sdo    = tx_sdo & sdo_oe;

  // write receive path
  logic [DW-2:0]     wr_sr;
  logic [DW-1:0]     wr_next, wr_mask_q;
  logic              wr_map_q, wr_en_q;
  logic [ADDR_W-1:0] wr_addr_q;
  logic [DW-1:0]     wr_data_q;

  assign wr_next = {wr_sr, bit_in};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q   <= PH_CMD;
      cmd_sr    <= '0;
      cnt_q     <= '0;
      wr_sr     <= '0;
      wr_mask_q <= '0;
      wr_map_q  <= 1'b0;
      wr_en_q   <= 1'b0;
      wr_addr_q <= '0;
      wr_data_q <= '0;
    end else begin
      wr_en_q <= 1'b0;
      if (!selected) begin
        phase_q <= PH_CMD;
        cnt_q   <= '0;
      end else begin
        case (phase_q)
          PH_CMD: if (sclk_fall) begin
            cmd_sr <= cmd_full[CMD_BITS-2:0];
            if (cmd_last) begin
              cnt_q     <= lut_frame;
              wr_sr     <= '0;
              wr_map_q  <= lut_mapped;
              wr_mask_q <= lut_mask;
              wr_addr_q <= rd_addr;
              phase_q   <= cmd_is_wr ? PH_WR : PH_RD;
            end else begin
              cnt_q <= cnt_q + CNT_W'(1);
            end
          end
          PH_WR: if (sclk_fall) begin
            wr_sr <= wr_next[DW-2:0];
            if (cnt_q == CNT_W'(1)) begin
              wr_en_q   <= wr_map_q;
              wr_data_q <= wr_next & wr_mask_q;
              cnt_q     <= '0;
              phase_q   <= PH_CMD;
            end else begin
              cnt_q <= cnt_q - CNT_W'(1);
            end
          end
          PH_RD: if (tx_release) begin
            cnt_q   <= '0;
            phase_q <= PH_CMD;
          end
          default: phase_q <= PH_CMD;
        endcase
      end
    end
  end

  assign wr_en   = wr_en_q;
  assign wr_addr = wr_addr_q;
  assign wr_data = wr_data_q;

  // R1: command counter never passes the command length
  p_cmd_cnt_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_q == PH_CMD) |-> (cnt_q < CNT_W'(CMD_BITS)));

  // R7: output only enabled in the read data phase
  p_oe_in_read_r7: assert property (@(posedge clk) disable iff (!rst_n)
    sdo_oe |-> (phase_q == PH_RD));

  // R4: write strobe lasts one cycle
  p_wr_single_r4: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> !wr_en);

  // R10: no strobe to an unmapped address
  p_wr_mapped_r10: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> MAP_MASK[wr_addr]);

  // R3: committed data fits the register width
  p_wr_fits_r3: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> ((wr_data >> code_data_bits(WCODE[2*wr_addr +: 2])) == '0));

  // R5: snapshot strobe is followed by the read data phase
  p_rd_enters_r5: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en |=> (phase_q == PH_RD));
endmodule

// File: tb/test_serreg_port.sv
module test_serreg_port;
  localparam int CLK_P = 10;
  localparam int HALF  = 4;
  localparam int NV    = 10;

  // {is_write, addr, data}
  localparam logic [29:0] VEC [NV] = '{
    {1'b1, 5'd0,  24'hABCDEF},
    {1'b1, 5'd1,  24'h00FF5A},
    {1'b1, 5'd2,  24'h001234},
    {1'b1, 5'd7,  24'h89ABCD},
    {1'b1, 5'd25, 24'h000077},
    {1'b0, 5'd3,  24'h123456},
    {1'b0, 5'd5,  24'h00FABC},
    {1'b0, 5'd6,  24'h00BEEF},
    {1'b0, 5'd4,  24'h0000A5},
    {1'b0, 5'd30, 24'h005555}
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        sclk = 1'b0, cs_n = 1'b1, sdi = 1'b0;
  logic        sdo, sdo_oe, rd_en, wr_en;
  logic [4:0]  rd_addr, wr_addr;
  logic [23:0] rd_data, wr_data;
  logic [23:0] bank [32];

  int checks = 0, errors = 0;
  int wr_cnt = 0, rd_cnt = 0;
  logic [4:0]  last_wa;
  logic [23:0] last_wd;
  bit done = 1'b0;

  always #(CLK_P/2) clk = ~clk;

  assign rd_data = bank[rd_addr];

  serreg_port i_serreg_port (
    .clk(clk), .rst_n(rst_n), .sclk(sclk), .cs_n(cs_n), .sdi(sdi),
    .sdo(sdo), .sdo_oe(sdo_oe), .rd_addr(rd_addr), .rd_en(rd_en),
    .rd_data(rd_data), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data)
  );

  always @(negedge clk) begin
    if (wr_en) begin
      wr_cnt++;
      last_wa = wr_addr;
      last_wd = wr_data;
    end
    if (rd_en) rd_cnt++;
  end

  function automatic bit is_mapped(input logic [4:0] a);
    return a < 5'd24;
  endfunction

  function automatic int frame_len(input logic [4:0] a);
    if (!is_mapped(a)) return 8;
    case (a[1:0])
      2'd0: return 8;
      2'd3: return 24;
      default: return 16;
    endcase
  endfunction

  function automatic logic [23:0] width_mask(input logic [4:0] a);
    if (!is_mapped(a)) return 24'h0;
    case (a[1:0])
      2'd0: return 24'h0000FF;
      2'd1: return 24'h000FFF;
      2'd2: return 24'h00FFFF;
      default: return 24'hFFFFFF;
    endcase
  endfunction

  task automatic chk(input string req, input logic [23:0] act, input logic [23:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic pulse(input logic b, output logic q, output logic oe);
    sdi = b;
    repeat (HALF) @(negedge clk);
    sclk = 1'b1;
    repeat (HALF) @(negedge clk);
    q  = sdo;
    oe = sdo_oe;
    sclk = 1'b0;
    repeat (HALF) @(negedge clk);
  endtask

  task automatic send_byte(input logic [7:0] b);
    logic q, oe;
    for (int i = 7; i >= 0; i--) pulse(b[i], q, oe);
  endtask

  task automatic cs_lo();
    cs_n = 1'b0;
    repeat (HALF) @(negedge clk);
  endtask

  task automatic cs_hi();
    cs_n = 1'b1;
    repeat (HALF) @(negedge clk);
  endtask

  task automatic wr_frame(input logic [4:0] a, input logic [23:0] d, input logic [1:0] pad);
    logic q, oe;
    send_byte({1'b1, pad, a});
    for (int i = frame_len(a) - 1; i >= 0; i--) pulse(d[i], q, oe);
    repeat (HALF) @(negedge clk);
  endtask

  task automatic rd_frame(input logic [4:0] a, input int chg_at, input logic [23:0] chg_v,
                          output logic [23:0] val, output logic oe_pre,
                          output logic oe_all, output logic oe_post);
    logic q, oe;
    send_byte({3'b000, a});
    repeat (HALF) @(negedge clk);
    oe_pre = sdo_oe;
    val = '0;
    oe_all = 1'b1;
    for (int i = 0; i < frame_len(a); i++) begin
      if (i == chg_at) bank[a] = chg_v;
      pulse(1'b0, q, oe);
      val = {val[22:0], q};
      oe_all = oe_all & oe;
    end
    repeat (HALF) @(negedge clk);
    oe_post = sdo_oe;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [23:0] val;
    logic oe_pre, oe_all, oe_post, q, oe;
    int n0, r0;
    for (int i = 0; i < 32; i++) bank[i] = 24'h0;

    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    // R11 reset state
    chk("R11 sdo_oe", {23'h0, sdo_oe}, 24'h0);
    chk("R11 sdo",    {23'h0, sdo},    24'h0);
    chk("R11 wr_en",  {23'h0, wr_en},  24'h0);
    chk("R11 rd_en",  {23'h0, rd_en},  24'h0);

    // vector table: R2 widths, R3/R4 writes, R5/R6/R7 reads, R10 unmapped
    for (int v = 0; v < NV; v++) begin
      logic        w;
      logic [4:0]  a;
      logic [23:0] d;
      w = VEC[v][29];
      a = VEC[v][28:24];
      d = VEC[v][23:0];
      if (w) begin
        n0 = wr_cnt;
        cs_lo();
        wr_frame(a, d, 2'b00);
        cs_hi();
        chk("R4/R10 write strobe count", 24'(wr_cnt - n0), is_mapped(a) ? 24'd1 : 24'd0);
        if (is_mapped(a)) begin
          chk("R4 write address", {19'h0, last_wa}, {19'h0, a});
          chk("R3/R2 write data", last_wd, d & width_mask(a));
        end
      end else begin
        bank[a] = d;
        r0 = rd_cnt;
        cs_lo();
        rd_frame(a, -1, 24'h0, val, oe_pre, oe_all, oe_post);
        cs_hi();
        chk("R6/R2/R10 read value", val, d & width_mask(a));
        chk("R7 oe before data", {23'h0, oe_pre}, 24'h0);
        chk("R7 oe during data", {23'h0, oe_all}, 24'h1);
        chk("R7 oe after last pulse", {23'h0, oe_post}, 24'h0);
        chk("R5 rd_en count", 24'(rd_cnt - r0), is_mapped(a) ? 24'd1 : 24'd0);
      end
    end

    // R1: command bits 6:5 ignored
    n0 = wr_cnt;
    cs_lo();
    wr_frame(5'd1, 24'h000ABC, 2'b11);
    cs_hi();
    chk("R1 padded command strobe", 24'(wr_cnt - n0), 24'd1);
    chk("R1 padded command addr", {19'h0, last_wa}, 24'd1);
    chk("R1 padded command data", last_wd, 24'h000ABC);

    // R5: snapshot survives a change mid-transfer
    bank[3] = 24'h123456;
    cs_lo();
    rd_frame(5'd3, 5, 24'hFFFFFF, val, oe_pre, oe_all, oe_post);
    cs_hi();
    chk("R5 snapshot value", val, 24'h123456);

    // R8: write then read under one select
    bank[4] = 24'h00005A;
    n0 = wr_cnt;
    cs_lo();
    wr_frame(5'd0, 24'h00003C, 2'b00);
    rd_frame(5'd4, -1, 24'h0, val, oe_pre, oe_all, oe_post);
    cs_hi();
    chk("R8 first write data", last_wd, 24'h00003C);
    chk("R8 first write count", 24'(wr_cnt - n0), 24'd1);
    chk("R8 second command read", val, 24'h00005A);

    // R9: abort a partial write
    n0 = wr_cnt;
    cs_lo();
    send_byte(8'h82);
    for (int i = 0; i < 5; i++) pulse(1'b1, q, oe);
    cs_hi();
    repeat (HALF) @(negedge clk);
    chk("R9 partial write dropped", 24'(wr_cnt - n0), 24'd0);

    // R9: abort a read, enable releases at once
    bank[7] = 24'hFFFFFF;
    cs_lo();
    send_byte(8'h07);
    for (int i = 0; i < 3; i++) pulse(1'b0, q, oe);
    chk("R9 oe high before abort", {23'h0, sdo_oe}, 24'h1);
    cs_n = 1'b1;
    #1;
    chk("R9 oe low on select rise", {23'h0, sdo_oe}, 24'h0);
    repeat (HALF) @(negedge clk);

    // R9: next select starts with a command
    n0 = wr_cnt;
    cs_lo();
    wr_frame(5'd2, 24'h004455, 2'b00);
    cs_hi();
    chk("R9 next select strobe", 24'(wr_cnt - n0), 24'd1);
    chk("R9 next select data", last_wd, 24'h004455);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule